// File: doc/BRIEF.md
# Link Speed and Duplex Arbitration Controller

This block is the control state machine that settles the operating speed (10 or 100 Mb/s) and the duplex of a 10/100 Ethernet transceiver. It does not touch the line itself. Detector circuits outside the block report four conditions: a fast link pulse burst has arrived, a normal link pulse has arrived, 100 Mb/s idle symbols are present, and the receive signal is present. The same detectors supply the partner's decoded ability word. The block drives four outputs: the resolved speed and duplex, a link-up flag, and an enable that stops transmit and receive while a link is being torn down.

A small register port with synchronous reads and writes gives a management agent three registers. The control register at address 0 enables negotiation, requests a restart, and holds the forced speed and duplex. The partner register at address 5 holds the partner's abilities. The expansion register at address 6 shows whether the partner can negotiate and whether parallel detection failed. The partner may be unable to negotiate. The block then classifies the line activity and links at half duplex. A restart or a loss of signal holds transmit and receive off for a break period before the search resumes. When negotiation is turned off, the control bits set the mode directly.

The state machine has four states. SEARCH watches the detectors. LINKED holds a resolved mode. BREAK holds the link down for the break period. FORCED follows the control bits. Its transitions are:
- SEARCH→LINKED on a usable pulse burst or on unambiguous line activity.
- SEARCH→SEARCH on a detection fault.
- LINKED→BREAK on signal loss.
- any→BREAK on a restart request, or when negotiation is switched back on from FORCED.
- BREAK→SEARCH when the break timer expires.
- any→FORCED while negotiation is disabled.

Top module: `link_arb_top`

## Requirements
- R1: In SEARCH with negotiation on, a pulse burst (this takes priority over the other detectors) loads the partner word into register 5 and sets expansion bit 0. The link then forms in the best mode present in the word, in the priority order bit 8 (100 full) > bit 7 (100 half) > bit 6 (10 full) > bit 5 (10 half). If none of these bits is set, no link forms and the search continues.
- R2: In SEARCH with no pulse burst, exactly one of the idle-symbol detector and the link-pulse detector forms a link. The speed is 100 for idle symbols and 10 for link pulses. The duplex is always half.
- R3: A link formed as in R2 clears expansion bit 0. It also loads register 5 with 0x0080 for 100 or 0x0020 for 10.
- R4: When both detectors of R2 are active in the same cycle without a pulse burst, expansion bit 4 is set, no link forms and SEARCH continues. Bit 4 is cleared by the next entry into BREAK.
- R5: Writing register 0 with bit 12 = 1 and bit 9 = 1 restarts negotiation from any state. Writing bit 12 from 0 to 1 also restarts it.
- R6: Loss of `sig_present` while LINKED with negotiation on restarts negotiation. `txrx_en` falls in the next cycle.
- R7: After a restart, `txrx_en` stays low for exactly BREAK_CYCLES cycles and then rises as SEARCH begins.
- R8: With register 0 bit 12 = 0, the outputs follow the control bits: speed_100 = bit 13, full_duplex = bit 8, link_up = sig_present.
- R9: With register 0 bit 12 = 1, writing bits 13 and 8 does not change speed_100, full_duplex or link_up.
- R10: Register 0 bit 9 clears itself once the restart is accepted. A read issued after the restart returns 0 in that bit.
- R11: `reg_rdata` presents the addressed register in the cycle after `reg_rd`. Register 0 implements bits 13, 12, 9 and 8, with the rest reading 0. Its reset value is 0x3000. Unmapped addresses read 0. Reset enters SEARCH with link_up = 0 and txrx_en = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flp_seen | input | 1 | Fast link pulse burst detected |
| nlp_seen | input | 1 | Normal link pulse detected |
| idle100_seen | input | 1 | 100 Mb/s idle symbols detected |
| partner_word | input | 16 | Partner ability word decoded from the burst |
| sig_present | input | 1 | Receive signal present |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 16 | Read data, valid the cycle after the strobe |
| link_up | output | 1 | Link established |
| speed_100 | output | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_duplex | output | 1 | 1 = full duplex |
| txrx_en | output | 1 | Transmit/receive enable, low during the break period |

## Verification
The bench builds the block with BREAK_CYCLES = 40 instead of the default of tens of millions. This makes every restart a short window whose exact length the bench can count edge by edge. The short window allows dozens of random detector patterns, each followed by a full break-and-search cycle, within a short run. It also brings the signal-loss, forced-mode and re-enable paths within reach of directed checks that count the exact release cycle.

// File: rtl/link_arb_pkg.sv
package link_arb_pkg;

    localparam int REG_W  = 16;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_CTRL = 5'd0;
    localparam logic [ADDR_W-1:0] A_PART = 5'd5;
    localparam logic [ADDR_W-1:0] A_EXPN = 5'd6;

    localparam int B_SPEED = 13;
    localparam int B_AN_EN = 12;
    localparam int B_RESTA = 9;
    localparam int B_DUPLX = 8;
    localparam int B_NEGO  = 0;
    localparam int B_FAULT = 4;

    localparam logic [REG_W-1:0] CTRL_STORE_MASK = 16'h3100;
    localparam logic [REG_W-1:0] CTRL_RESET      = 16'h3000;
    localparam logic [REG_W-1:0] PD_WORD_100     = 16'h0080;
    localparam logic [REG_W-1:0] PD_WORD_10      = 16'h0020;

    typedef enum logic [1:0] {
        ST_SEARCH,
        ST_BREAK,
        ST_LINKED,
        ST_FORCED
    } la_state_e;

    typedef struct packed {
        logic ok;
        logic spd100;
        logic fdx;
    } la_mode_t;

    function automatic la_mode_t la_pick(input logic [REG_W-1:0] w);
        la_mode_t m;
        m = '0;
        if (w[8])      m = '{ok: 1'b1, spd100: 1'b1, fdx: 1'b1};
        else if (w[7]) m = '{ok: 1'b1, spd100: 1'b1, fdx: 1'b0};
        else if (w[6]) m = '{ok: 1'b1, spd100: 1'b0, fdx: 1'b1};
        else if (w[5]) m = '{ok: 1'b1, spd100: 1'b0, fdx: 1'b0};
        return m;
    endfunction

endpackage

// File: rtl/link_arb_brk.sv
module link_arb_brk #(
    parameter int BREAK_CYCLES = 30_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(BREAK_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(BREAK_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == LAST);
endmodule

// File: rtl/link_arb_regs.sv
module link_arb_regs
    import link_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              rd,
    output logic [REG_W-1:0]  rdata,
    output logic              an_en,
    output logic              force_spd,
    output logic              force_dup,
    output logic              restart_req,
    input  logic              restart_ack,
    input  logic              part_ld,
    input  logic [REG_W-1:0]  part_val,
    input  logic              nego_ld,
    input  logic              nego_val,
    input  logic              fault_set,
    input  logic              fault_clr,
    output logic              nego_bit,
    output logic              fault_bit
);
    logic [REG_W-1:0] ctrl_q, part_q, rd_val;
    logic             rst_q, nego_q, fault_q;
    logic             wr_ctrl;

    assign wr_ctrl = wr && (addr == A_CTRL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_RESET;
            rst_q   <= 1'b0;
            part_q  <= '0;
            nego_q  <= 1'b0;
            fault_q <= 1'b0;
            rdata   <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= wdata & CTRL_STORE_MASK;
                rst_q  <= wdata[B_RESTA] & wdata[B_AN_EN];
            end else if (restart_ack) begin
                rst_q  <= 1'b0;
            end
            if (part_ld)        part_q  <= part_val;
            if (nego_ld)        nego_q  <= nego_val;
            if (fault_set)      fault_q <= 1'b1;
            else if (fault_clr) fault_q <= 1'b0;
            if (rd)             rdata   <= rd_val;
        end
    end

    always_comb begin
        rd_val = '0;
        case (addr)
            A_CTRL: begin
                rd_val          = ctrl_q;
                rd_val[B_RESTA] = rst_q;
            end
            A_PART: rd_val = part_q;
            A_EXPN: begin
                rd_val[B_NEGO]  = nego_q;
                rd_val[B_FAULT] = fault_q;
            end
            default: rd_val = '0;
        endcase
    end

    assign an_en       = ctrl_q[B_AN_EN];
    assign force_spd   = ctrl_q[B_SPEED];
    assign force_dup   = ctrl_q[B_DUPLX];
    assign restart_req = rst_q;
    assign nego_bit    = nego_q;
    assign fault_bit   = fault_q;
endmodule

// File: rtl/link_arb_fsm.sv
module link_arb_fsm
    import link_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flp_seen,
    input  logic             nlp_seen,
    input  logic             idle100_seen,
    input  logic             sig_present,
    input  logic [REG_W-1:0] partner_word,
    input  logic             an_en,
    input  logic             force_spd,
    input  logic             force_dup,
    input  logic             restart_req,
    input  logic             brk_done,
    output la_state_e        st,
    output logic             restart_ack,
    output logic             brk_run,
    output logic             part_ld,
    output logic [REG_W-1:0] part_val,
    output logic             nego_ld,
    output logic             nego_val,
    output logic             fault_set,
    output logic             fault_clr,
    output logic             link_up,
    output logic             speed_100,
    output logic             full_duplex,
    output logic             txrx_en
);
    la_state_e nxt;
    la_mode_t  pick;
    logic      res_ld, res_spd_n, res_fdx_n, res_spd_q, res_fdx_q;

    // next-state and register-update decisions
    always_comb begin
        nxt         = st;
        res_ld      = 1'b0;
        res_spd_n   = res_spd_q;
        res_fdx_n   = res_fdx_q;
        part_ld     = 1'b0;
        part_val    = partner_word;
        nego_ld     = 1'b0;
        nego_val    = 1'b0;
        fault_set   = 1'b0;
        restart_ack = restart_req;
        pick        = la_pick(partner_word);
        if (!an_en) begin
            nxt = ST_FORCED;
        end else if (restart_req || st == ST_FORCED) begin
            nxt = ST_BREAK;
        end else begin
            unique case (st)
                ST_SEARCH: begin
                    if (flp_seen) begin
                        part_ld  = 1'b1;
                        nego_ld  = 1'b1;
                        nego_val = 1'b1;
                        if (pick.ok) begin
                            nxt       = ST_LINKED;
                            res_ld    = 1'b1;
                            res_spd_n = pick.spd100;
                            res_fdx_n = pick.fdx;
                        end
                    end else if (idle100_seen && nlp_seen) begin
                        fault_set = 1'b1;
                    end else if (idle100_seen || nlp_seen) begin
                        nxt       = ST_LINKED;
                        res_ld    = 1'b1;
                        res_spd_n = idle100_seen;
                        res_fdx_n = 1'b0;
                        part_ld   = 1'b1;
                        part_val  = idle100_seen ? PD_WORD_100 : PD_WORD_10;
                        nego_ld   = 1'b1;
                        nego_val  = 1'b0;
                    end
                end
                ST_BREAK:  if (brk_done) nxt = ST_SEARCH;
                ST_LINKED: if (!sig_present) nxt = ST_BREAK;
                ST_FORCED: nxt = ST_FORCED;
            endcase
        end
        fault_clr = (nxt == ST_BREAK) && (st != ST_BREAK);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_SEARCH;
            res_spd_q <= 1'b0;
            res_fdx_q <= 1'b0;
        end else begin
            st <= nxt;
            if (res_ld) begin
                res_spd_q <= res_spd_n;
                res_fdx_q <= res_fdx_n;
            end
        end
    end

    // outputs
    always_comb begin
        brk_run     = (st == ST_BREAK) && !(an_en && restart_req);
        txrx_en     = (st != ST_BREAK);
        link_up     = (st == ST_LINKED) || (st == ST_FORCED && sig_present);
        speed_100   = (st == ST_FORCED) ? force_spd : res_spd_q;
        full_duplex = (st == ST_FORCED) ? force_dup : res_fdx_q;
    end
endmodule

// File: rtl/link_arb_top.sv
module link_arb_top
    import link_arb_pkg::*;
#(
    parameter int BREAK_CYCLES = 30_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flp_seen,
    input  logic        nlp_seen,
    input  logic        idle100_seen,
    input  logic [15:0] partner_word,
    input  logic        sig_present,
    input  logic [4:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [15:0] reg_wdata,
    input  logic        reg_rd,
    output logic [15:0] reg_rdata,
    output logic        link_up,
    output logic        speed_100,
    output logic        full_duplex,
    output logic        txrx_en
);
    la_state_e        st;
    logic             an_en, force_spd, force_dup, restart_req, restart_ack;
    logic             brk_run, brk_done;
    logic             part_ld, nego_ld, nego_val, fault_set, fault_clr;
    logic             nego_bit, fault_bit;
    logic [REG_W-1:0] part_val;

    link_arb_regs u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
        .rd(reg_rd), .rdata(reg_rdata), .an_en(an_en), .force_spd(force_spd),
        .force_dup(force_dup), .restart_req(restart_req), .restart_ack(restart_ack),
        .part_ld(part_ld), .part_val(part_val), .nego_ld(nego_ld), .nego_val(nego_val),
        .fault_set(fault_set), .fault_clr(fault_clr), .nego_bit(nego_bit),
        .fault_bit(fault_bit)
    );

    link_arb_brk #(.BREAK_CYCLES(BREAK_CYCLES)) u_brk (
        .clk(clk), .rst_n(rst_n), .run(brk_run), .done(brk_done)
    );

    link_arb_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .flp_seen(flp_seen), .nlp_seen(nlp_seen),
        .idle100_seen(idle100_seen), .sig_present(sig_present),
        .partner_word(partner_word), .an_en(an_en), .force_spd(force_spd),
        .force_dup(force_dup), .restart_req(restart_req), .brk_done(brk_done),
        .st(st), .restart_ack(restart_ack), .brk_run(brk_run), .part_ld(part_ld),
        .part_val(part_val), .nego_ld(nego_ld), .nego_val(nego_val),
        .fault_set(fault_set), .fault_clr(fault_clr), .link_up(link_up),
        .speed_100(speed_100), .full_duplex(full_duplex), .txrx_en(txrx_en)
    );
endmodule

// File: rtl/link_arb_chk.sv
module link_arb_chk
    import link_arb_pkg::*;
#(
    parameter int BREAK_CYCLES = 30_000_000
) (
    input logic      clk,
    input logic      rst_n,
    input la_state_e st,
    input logic      an_en,
    input logic      restart_req,
    input logic      reg_wr,
    input logic      flp_seen,
    input logic      nlp_seen,
    input logic      idle100_seen,
    input logic      sig_present,
    input logic      nego_bit,
    input logic      fault_bit,
    input logic      link_up,
    input logic      speed_100,
    input logic      full_duplex,
    input logic      txrx_en
);
    localparam int LW = $clog2(BREAK_CYCLES + 2);
    localparam logic [LW-1:0] LMAX = {LW{1'b1}};

    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || txrx_en) low_cnt <= '0;
        else if (low_cnt != LMAX) low_cnt <= low_cnt + 1'b1;
    end

    // R7: release only after the full break period
    p_break_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(txrx_en) && an_en) |-> (low_cnt >= LW'(BREAK_CYCLES)));

    // R2: parallel-detected link is half duplex
    p_pd_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LINKED && !nego_bit) |-> !full_duplex);

    // R6: signal loss tears the link down
    p_loss_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LINKED && an_en && !restart_req && !sig_present) |=> !txrx_en);

    // R10: restart request clears itself
    p_restart_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_req && !reg_wr) |=> !restart_req);

    // R4: ambiguous activity flags a fault and gives no link
    p_fault_nolink_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SEARCH && an_en && !restart_req && !flp_seen && idle100_seen && nlp_seen)
        |=> (!link_up && fault_bit));

    // R9: resolved mode holds while linked
    p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LINKED && $past(st) == ST_LINKED) |-> ($stable(speed_100) && $stable(full_duplex)));
endmodule

bind link_arb_top link_arb_chk #(.BREAK_CYCLES(BREAK_CYCLES)) u_link_arb_chk (
    .clk(clk), .rst_n(rst_n), .st(st), .an_en(an_en), .restart_req(restart_req),
    .reg_wr(reg_wr), .flp_seen(flp_seen), .nlp_seen(nlp_seen),
    .idle100_seen(idle100_seen), .sig_present(sig_present), .nego_bit(nego_bit),
    .fault_bit(fault_bit), .link_up(link_up), .speed_100(speed_100),
    .full_duplex(full_duplex), .txrx_en(txrx_en)
);

// File: tb/test_link_arb_top.sv
`timescale 1ns/1ps
module test_link_arb_top;
    localparam int BC = 40;

    logic        clk = 1'b0;
    logic        rst_n, flp_seen, nlp_seen, idle100_seen, sig_present;
    logic [15:0] partner_word, reg_wdata, reg_rdata;
    logic [4:0]  reg_addr;
    logic        reg_wr, reg_rd, link_up, speed_100, full_duplex, txrx_en;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] m_r5;
    logic        m_nego, m_fault;

    always #2.5 clk = ~clk;

    link_arb_top #(.BREAK_CYCLES(BC)) i_link_arb_top (
        .clk(clk), .rst_n(rst_n), .flp_seen(flp_seen), .nlp_seen(nlp_seen),
        .idle100_seen(idle100_seen), .partner_word(partner_word),
        .sig_present(sig_present), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .link_up(link_up), .speed_100(speed_100), .full_duplex(full_duplex),
        .txrx_en(txrx_en)
    );

    function automatic logic [2:0] exp_mode(input logic [15:0] w);
        if (w[8]) return 3'b111;
        if (w[7]) return 3'b110;
        if (w[6]) return 3'b101;
        if (w[5]) return 3'b100;
        return 3'b000;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic restart_check();
        logic [15:0] v;
        wr_reg(5'd0, 16'h3200);
        @(negedge clk);
        chk("R5 restart drops txrx_en", 16'(txrx_en), 16'h0);
        repeat (BC - 1) @(negedge clk);
        chk("R7 held through break", 16'(txrx_en), 16'h0);
        @(negedge clk);
        chk("R7 released after break", 16'(txrx_en), 16'h1);
        m_fault = 1'b0;
        rd_reg(5'd0, v);
        chk("R10 restart bit self-clears", v, 16'h3000);
    endtask

    task automatic trial(input int kind, input logic [15:0] w);
        logic [15:0] v;
        logic [2:0]  e;
        logic        exp_link, exp_spd, exp_fdx;
        string       tg;
        exp_link = 1'b0; exp_spd = 1'b0; exp_fdx = 1'b0;
        @(negedge clk);
        partner_word = w;
        flp_seen     = (kind == 0);
        idle100_seen = (kind == 1 || kind == 3) || (kind == 0 && $urandom_range(0, 1) == 1);
        nlp_seen     = (kind == 2 || kind == 3) || (kind == 0 && $urandom_range(0, 1) == 1);
        @(negedge clk);
        flp_seen = 1'b0; idle100_seen = 1'b0; nlp_seen = 1'b0;
        case (kind)
            0: begin
                e = exp_mode(w);
                m_r5 = w; m_nego = 1'b1;
                exp_link = e[2]; exp_spd = e[1]; exp_fdx = e[0];
                tg = "R1";
            end
            1: begin m_r5 = 16'h0080; m_nego = 1'b0; exp_link = 1'b1; exp_spd = 1'b1; tg = "R2"; end
            2: begin m_r5 = 16'h0020; m_nego = 1'b0; exp_link = 1'b1; exp_spd = 1'b0; tg = "R2"; end
            default: begin m_fault = 1'b1; tg = "R4"; end
        endcase
        chk({tg, " link_up"}, 16'(link_up), 16'(exp_link));
        if (exp_link) begin
            chk({tg, " speed_100"}, 16'(speed_100), 16'(exp_spd));
            chk({tg, " full_duplex"}, 16'(full_duplex), 16'(exp_fdx));
        end
        rd_reg(5'd5, v);
        chk((kind == 1 || kind == 2) ? "R3 partner register" : "R1 partner register", v, m_r5);
        rd_reg(5'd6, v);
        chk((kind == 3) ? "R4 expansion register" : "R3 expansion register", v,
            {11'd0, m_fault, 3'd0, m_nego});
        if (kind == 3) chk("R4 still searching", 16'(link_up), 16'h0);
        restart_check();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; flp_seen = 1'b0; nlp_seen = 1'b0; idle100_seen = 1'b0;
        sig_present = 1'b1; partner_word = '0; reg_addr = '0; reg_wdata = '0;
        reg_wr = 1'b0; reg_rd = 1'b0;
        m_r5 = '0; m_nego = 1'b0; m_fault = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset link_up", 16'(link_up), 16'h0);
        chk("R11 reset txrx_en", 16'(txrx_en), 16'h1);
        rd_reg(5'd0, v);
        chk("R11 reset control register", v, 16'h3000);
        rd_reg(5'd3, v);
        chk("R11 unmapped read", v, 16'h0);

        // directed corner cases
        trial(1, 16'h0000);
        trial(2, 16'h0000);
        trial(3, 16'h0000);
        trial(0, 16'h0020);
        trial(0, 16'h0000);
        trial(0, 16'h01E0);

        // R9: control bits ignored while negotiating
        @(negedge clk); nlp_seen = 1'b1;
        @(negedge clk); nlp_seen = 1'b0;
        m_r5 = 16'h0020; m_nego = 1'b0;
        wr_reg(5'd0, 16'h3100);
        @(negedge clk);
        chk("R9 speed unchanged", 16'(speed_100), 16'h0);
        chk("R9 duplex unchanged", 16'(full_duplex), 16'h0);
        chk("R9 link unchanged", 16'(link_up), 16'h1);

        // R6: signal loss
        @(negedge clk); sig_present = 1'b0;
        @(negedge clk);
        chk("R6 loss drops txrx_en", 16'(txrx_en), 16'h0);
        chk("R6 loss drops link", 16'(link_up), 16'h0);
        sig_present = 1'b1;
        repeat (BC + 2) @(negedge clk);
        chk("R6 search resumes", 16'(txrx_en), 16'h1);

        // R8: forced mode
        wr_reg(5'd0, 16'h0100);
        @(negedge clk);
        chk("R8 forced link", 16'(link_up), 16'h1);
        chk("R8 forced speed 10", 16'(speed_100), 16'h0);
        chk("R8 forced full duplex", 16'(full_duplex), 16'h1);
        wr_reg(5'd0, 16'h2000);
        chk("R8 forced speed 100", 16'(speed_100), 16'h1);
        chk("R8 forced half duplex", 16'(full_duplex), 16'h0);
        @(negedge clk); sig_present = 1'b0;
        @(negedge clk);
        chk("R8 forced link follows signal", 16'(link_up), 16'h0);
        sig_present = 1'b1;
        wr_reg(5'd0, 16'h3000);
        @(negedge clk);
        chk("R5 re-enable restarts", 16'(txrx_en), 16'h0);
        repeat (BC + 2) @(negedge clk);
        chk("R7 search after re-enable", 16'(txrx_en), 16'h1);

        // random patterns
        for (int i = 0; i < 40; i++) begin
            int          k;
            logic [15:0] w;
            k = $urandom_range(0, 3);
            w = 16'($urandom);
            if ($urandom_range(0, 3) == 0) w = w & 16'hFE1F;
            trial(k, w);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule